// File: doc/BRIEF.md
# Daisy-Chainable Serial Gain Port

This block receives stereo gain settings over a three-wire serial link: an active-low select, a serial clock and a data line. One frame is sixteen bits and holds two 8-bit gain codes in straight binary, each sent most significant bit first. The first byte of the frame is the right-channel code and the second byte is the left-channel code. The select, clock and data pins are asynchronous to the system clock. They pass through a two-flop synchroniser and an edge detector, and every action is taken on the system clock. Each phase of the serial clock, high and low, must last at least three system clock periods.

Each incoming bit enters a 16-bit shift register. The bit that falls off the far end is driven on a serial output, which changes only on falling serial clock edges. That output goes to the data input of the next port, so several ports form one long shift register. For a chain of N ports, the host holds select low for 16×N clock periods. When select returns high, every port copies its shift register to its two gain outputs and pulses an update strobe for each channel. The serial output carries an enable that is low whenever the port is not selected, so a pad can place it in high impedance.

Control is a three-state machine:
- IDLE waits for select to go low (transition IDLE→SHIFT).
- SHIFT shifts on rising clock edges and drives the output on falling edges. It leaves on a rising select edge (SHIFT→COMMIT).
- COMMIT lasts one cycle and triggers the gain transfer. It then returns to IDLE, or to SHIFT if select is already low again (COMMIT→IDLE, COMMIT→SHIFT).

Top module: `sgp_gain_port`

## Requirements
- R1: While csn_i is high, sclk_i and sdi_i have no effect. No bit is shifted, sdo_oe_o stays low, sdo_o holds its value and no update strobe is raised.
- R2: While csn_i is low, sdi_i is sampled on each rising sclk_i edge. A frame is 16 bits, most significant bit first, in straight binary.
- R3: The first 8 bits of a 16-bit frame form right_gain_o and the last 8 bits form left_gain_o. In the shift register, bits [15:8] hold the right-channel code and bits [7:0] hold the left-channel code.
- R4: sdo_o changes only on a falling sclk_i edge while the port is selected. Just before each rising sclk_i edge, sdo_o equals the bit that this edge pushes out of the 16-bit shift register, which was received 16 rising edges earlier.
- R5: sdo_oe_o is high while the port is selected. It is low from the third system clock edge after csn_i is seen high, and stays low while csn_i stays high.
- R6: With two ports chained (sdo_o to sdi_i) and 32 clocks in one select window, the downstream port receives the first 16 bits and the upstream port receives the last 16 bits.
- R7: After reset, both gain codes are 0x00, both strobes are low, sdo_oe_o is low and sdo_o is 0.
- R8: On a rising csn_i edge, both gain codes load from the shift register. right_upd_o and left_upd_o then pulse together for exactly one cycle, on the fourth system clock rising edge after the csn_i edge. The gain codes change at no other time.
- R9: A select window with fewer than 16 clocks, or with none, still loads the last 16 bits shifted in, including bits from earlier windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out to the next port in the chain |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |
| right_gain_o | output | 8 | Right-channel gain code |
| right_upd_o | output | 1 | One-cycle strobe when right_gain_o is loaded |
| left_gain_o | output | 8 | Left-channel gain code |
| left_upd_o | output | 1 | One-cycle strobe when left_gain_o is loaded |

## Verification
The assertions check the following on every cycle:
- the two strobes are always equal and never last more than one cycle;
- a gain code changes only in a strobe cycle;
- a strobe follows only a selected window;
- sdo_o moves only while the port is selected;
- the enable is low three samples after select is high.

Only the bench scenarios can show the rest:
- the order of the two bytes and bit order within each byte;
- the far-end bit on sdo_o at each rising edge;
- the split of a 32-bit frame across two chained ports;
- short and empty windows reloading earlier bits;
- the exact four-cycle strobe latency.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

    // Control states of the serial port
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,   // not selected
        PS_SHIFT  = 2'd1,   // selected, shifting
        PS_COMMIT = 2'd2    // one cycle: transfer frame to gain outputs
    } port_state_e;

endpackage

// File: rtl/sgp_sync.sv
module sgp_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sgp_edge.sv
module sgp_edge #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/sgp_shift.sv
module sgp_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en_i,   // selected rising serial edge
    input  logic               drive_en_i,   // selected falling serial edge
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               sdo_o
);

    logic [FRAME_W-1:0] sr_q;
    logic               out_q;

    // Shift register keeps its contents across windows
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sr_q <= '0;
        else if (shift_en_i) sr_q <= {sr_q[FRAME_W-2:0], bit_i};
    end

    // Far-end bit presented on the falling edge for the next device
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          out_q <= 1'b0;
        else if (drive_en_i) out_q <= sr_q[FRAME_W-1];
    end

    assign frame_o = sr_q;
    assign sdo_o   = out_q;

endmodule

// File: rtl/sgp_fsm.sv
module sgp_fsm
    import sgp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_i,     // synchronised select, active low
    output logic active_o,
    output logic commit_o
);

    port_state_e state_q, state_d;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:   if (!sel_n_i) state_d = PS_SHIFT;
            PS_SHIFT:  if (sel_n_i)  state_d = PS_COMMIT;
            PS_COMMIT: state_d = sel_n_i ? PS_IDLE : PS_SHIFT;
            default:   state_d = PS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        active_o = 1'b0;
        commit_o = 1'b0;
        unique case (state_q)
            PS_IDLE:   ;
            PS_SHIFT:  active_o = 1'b1;
            PS_COMMIT: commit_o = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/sgp_gain_port.sv
module sgp_gain_port #(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [CODE_W-1:0] right_gain_o,
    output logic              right_upd_o,
    output logic [CODE_W-1:0] left_gain_o,
    output logic              left_upd_o
);

    localparam int FRAME_W = 2 * CODE_W;
    localparam int PIN_N   = 3;
    localparam int SEL_IX  = 2;
    localparam int CLK_IX  = 1;
    localparam int DAT_IX  = 0;

    logic [PIN_N-1:0]   pins_s;
    logic [1:0]         edge_rise, edge_fall;
    logic               active, commit;
    logic [FRAME_W-1:0] frame;
    logic [CODE_W-1:0]  right_q, left_q;
    logic               upd_q;

    // Select idles high, clock and data low
    sgp_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({csn_i, sclk_i, sdi_i}),
        .q_o   (pins_s)
    );

    // Edge detection on the serial clock (bit 0) and select (bit 1)
    sgp_edge #(
        .W       (2),
        .RST_VAL (2'b10)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({pins_s[SEL_IX], pins_s[CLK_IX]}),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    sgp_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_i  (pins_s[SEL_IX]),
        .active_o (active),
        .commit_o (commit)
    );

    sgp_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (active & edge_rise[0]),
        .drive_en_i (active & edge_fall[0]),
        .bit_i      (pins_s[DAT_IX]),
        .frame_o    (frame),
        .sdo_o      (sdo_o)
    );

    // Gain transfer: first byte is right, second byte is left
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            right_q <= '0;
            left_q  <= '0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= commit;
            if (commit) begin
                right_q <= frame[FRAME_W-1:CODE_W];
                left_q  <= frame[CODE_W-1:0];
            end
        end
    end

    assign sdo_oe_o     = active;
    assign right_gain_o = right_q;
    assign left_gain_o  = left_q;
    assign right_upd_o  = upd_q;
    assign left_upd_o   = upd_q;

endmodule

// File: rtl/sgp_gain_port_chk.sv
module sgp_gain_port_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_i,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic [CODE_W-1:0] right_gain_o,
    input logic              right_upd_o,
    input logic [CODE_W-1:0] left_gain_o,
    input logic              left_upd_o
);

    // R8: strobes are single-cycle and paired
    a_r8_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
        right_upd_o |=> !right_upd_o);
    a_r8_upd_paired: assert property (@(posedge clk) disable iff (!rst_n)
        right_upd_o == left_upd_o);

    // R8: gain codes move only with their strobe
    a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !right_upd_o |-> $stable(right_gain_o));
    a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !left_upd_o |-> $stable(left_gain_o));

    // R1: an update only follows a selected window
    a_r1_upd_after_active: assert property (@(posedge clk) disable iff (!rst_n)
        right_upd_o |-> $past(sdo_oe_o, 2));

    // R4: serial output moves only while selected
    a_r4_sdo_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> $past(sdo_oe_o));

    // R5: enable low once select has been high for the sync latency
    a_r5_oe_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csn_i, 3) |-> !sdo_oe_o);

endmodule

bind sgp_gain_port sgp_gain_port_chk #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csn_i        (csn_i),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o),
    .right_gain_o (right_gain_o),
    .right_upd_o  (right_upd_o),
    .left_gain_o  (left_gain_o),
    .left_upd_o   (left_upd_o)
);

// File: tb/sgp_gain_port_bench.sv
module sgp_gain_port_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;

    logic       d1_sdo, d1_oe, d1_rupd, d1_lupd;
    logic [7:0] d1_r, d1_l;
    logic       d2_sdo, d2_oe, d2_rupd, d2_lupd;
    logic [7:0] d2_r, d2_l;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [31:0] chain = '0;   // [15:0] upstream port, [31:16] downstream port

    always #4 clk = ~clk;   // 125 MHz

    sgp_gain_port u_sgp_gain_port (
        .clk (clk), .rst_n (rst_n), .csn_i (csn), .sclk_i (sclk), .sdi_i (sdi),
        .sdo_o (d1_sdo), .sdo_oe_o (d1_oe),
        .right_gain_o (d1_r), .right_upd_o (d1_rupd),
        .left_gain_o (d1_l), .left_upd_o (d1_lupd)
    );

    sgp_gain_port u_sgp_gain_port_far (
        .clk (clk), .rst_n (rst_n), .csn_i (csn), .sclk_i (sclk), .sdi_i (d1_sdo),
        .sdo_o (d2_sdo), .sdo_oe_o (d2_oe),
        .right_gain_o (d2_r), .right_upd_o (d2_rupd),
        .left_gain_o (d2_l), .left_upd_o (d2_lupd)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_right(input logic [31:0] c, input bit far);
        return far ? c[31:24] : c[15:8];
    endfunction

    function automatic logic [7:0] exp_left(input logic [31:0] c, input bit far);
        return far ? c[23:16] : c[7:0];
    endfunction

    // One select window with nbits clocks, word sent MSB first
    task automatic run_frame(input int nbits, input logic [31:0] word, input int ph);
        int first_hit;
        int hits;
        csn  = 1'b0;
        sclk = 1'b0;
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = word[i];
            wait_cyc(ph);
            check_eq("R4 sdo far-end bit", {31'd0, d1_sdo}, {31'd0, chain[15]});
            sclk  = 1'b1;
            chain = {chain[30:0], word[i]};
            wait_cyc(ph);
            sclk = 1'b0;
        end
        wait_cyc(ph);
        if (nbits > 0)
            check_eq("R5 oe high while selected", {30'd0, d1_oe, d2_oe}, 32'd3);
        csn = 1'b1;
        first_hit = 0;
        hits = 0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (d1_rupd && d1_lupd && d2_rupd) begin
                hits++;
                if (first_hit == 0) first_hit = c;
            end
        end
        check_eq("R8 strobe latency", first_hit, 4);
        check_eq("R8 strobe width", hits, 1);
        check_eq("R5 oe low after deselect", {30'd0, d1_oe, d2_oe}, 32'd0);
        check_eq("R3 near right", d1_r, exp_right(chain, 1'b0));
        check_eq("R3 near left",  d1_l, exp_left(chain, 1'b0));
        check_eq("R6 far right",  d2_r, exp_right(chain, 1'b1));
        check_eq("R6 far left",   d2_l, exp_left(chain, 1'b1));
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        logic sdo_before;
        seed_v = $urandom(32'd7211);

        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        // R7 reset state
        check_eq("R7 reset gains", {d1_r, d1_l, d2_r, d2_l}, 32'd0);
        check_eq("R7 reset strobes/oe/sdo", {d1_rupd, d1_lupd, d1_oe, d1_sdo}, 32'd0);

        // R2/R3 directed: right 0xA5 first, left 0x3C second
        run_frame(16, 32'h0000_A53C, 3);
        check_eq("R3 right byte first", d1_r, 8'hA5);
        check_eq("R2 left byte MSB first", d1_l, 8'h3C);

        // R1 clock and data toggled while deselected
        sdo_before = d1_sdo;
        for (int k = 0; k < 20; k++) begin
            sdi  = k[0];
            sclk = ~sclk;
            wait_cyc(3);
            check_eq("R1 no strobe/oe while deselected",
                     {d1_rupd, d1_oe, d2_rupd, d2_oe}, 32'd0);
        end
        sclk = 1'b0;
        wait_cyc(3);
        check_eq("R1 sdo held while deselected", {31'd0, d1_sdo}, {31'd0, sdo_before});
        run_frame(0, 32'd0, 3);
        check_eq("R1 shift register untouched", {d1_r, d1_l}, 32'h0000_A53C);

        // R6 two-port chain, 32 clocks
        run_frame(32, 32'h1122_FE01, 4);
        check_eq("R6 far port gets first word", {d2_r, d2_l}, 32'h0000_1122);
        check_eq("R6 near port gets last word", {d1_r, d1_l}, 32'h0000_FE01);

        // R9 short frame keeps earlier bits
        run_frame(5, 32'h0000_0015, 3);
        check_eq("R9 short frame", {d1_r, d1_l}, 32'h0000_C035);

        // Boundary codes
        run_frame(16, 32'h0000_FF00, 5);
        check_eq("R2 code 0xFF/0x00", {d1_r, d1_l}, 32'h0000_FF00);
        run_frame(16, 32'h0000_00FF, 3);
        check_eq("R2 code 0x00/0xFF", {d1_r, d1_l}, 32'h0000_00FF);

        // Random windows
        for (int n = 0; n < 24; n++) begin
            int nb;
            int ph;
            case ($urandom_range(3, 0))
                0:       nb = 16;
                1:       nb = 32;
                default: nb = int'($urandom_range(31, 0));
            endcase
            ph = 3 + int'($urandom_range(2, 0));
            run_frame(nb, $urandom(), ph);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule